// File: doc/BRIEF.md
# Byte-Wide Data Space with Pointer-Redirected Access Ports

This block implements a 128-location, byte-wide data space. The lower 64 addresses form a register region, where a fixed set of slots hold storage and the remaining slots are holes. The upper 64 addresses form general-purpose RAM. One address input serves reads, byte writes and single-bit set/clear operations. Read data follows the address combinationally, and every update lands on the rising clock edge.

Two addresses in the register region hold no storage of their own. They act as access ports. An access to port 0 (address 00H) goes to the location named by the pointer at 01H. An access to port 1 (address 02H) goes to the location named by the pointer at 03H. A bit operation reads the target byte, changes one bit and writes the byte back in the same cycle. It follows the same redirection and hole rules as a byte write. The peripheral slots are modelled only as plain storage.

Top module: `dmem_space`

## Requirements
- R1: After reset, every implemented location holds 00H, so a read of any address returns 00H.
- R2: A byte write (`wr_en`=1) to RAM (40H..7FH) or to an implemented register slot is visible on `rdata` from the cycle after the clock edge. Read data is combinational from `addr`.
- R3: An access to address 00H is redirected to the location whose address is the low 7 bits of the pointer at 01H. Bit 7 of the pointer is ignored for addressing.
- R4: An access to address 02H is redirected in the same way through the pointer at 03H.
- R5: If a port's pointer selects 00H or 02H in its low 7 bits, a read through that port returns 00H, and a byte write or bit operation through it changes nothing.
- R6: Holes in the register region read as 00H and ignore byte writes. The holes are every address below 40H except 00H, 02H and the implemented slots.
- R7: With `bit_en`=1 and `wr_en`=0, bit `bit_idx` (0 is the LSB) of the target is set when `bit_set`=1 and cleared when `bit_set`=0. All other bits are unchanged.
- R8: Bit operations follow the redirection of R3 and R4, the no-effect rule of R5 and the hole rule of R6.
- R9: When `wr_en` and `bit_en` are both 1, the byte write wins and `wdata` is stored as a whole.
- R10: The implemented register slots are 01H, 03H, 04H..0BH, 12H, 14H, 1EH and 20H..25H. Each is read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 7 | Location address (direct or port) |
| wdata | input | 8 | Byte write data |
| wr_en | input | 1 | Byte write strobe |
| bit_en | input | 1 | Bit set/clear strobe |
| bit_idx | input | 3 | Bit position for bit operations |
| bit_set | input | 1 | 1 = set bit, 0 = clear bit |
| rdata | output | 8 | Read data of the target location |

## Verification
A wrong pointer decode shows at the ports in the same cycle, because `rdata` through a port then follows the wrong location. A write that lands on the wrong slot, a hole or a null target shows as a stale or non-zero byte on the next read of the damaged or expected location, at the earliest one cycle after the edge. A reference model of all 128 locations is compared with `rdata` on every cycle, so each such corruption is reported on the first later read of the affected address. Random traffic is biased toward the two ports and their pointers, so these reads follow quickly.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int RAM_BASE  = 64;
  localparam int PORT0_A   = 0;
  localparam int PTR0_A    = 1;
  localparam int PORT1_A   = 2;
  localparam int PTR1_A    = 3;

  // R10: implemented slots of the register region
  function automatic logic is_reg_slot(int a);
    case (a)
      1, 3, 18, 20, 30: return 1'b1;
      default: return ((a >= 4) && (a <= 11)) || ((a >= 32) && (a <= 37));
    endcase
  endfunction

  // R7: single-bit read-modify-write
  function automatic logic [DATA_W-1:0] bit_apply(logic [DATA_W-1:0] v,
                                                  logic [2:0] idx, logic val);
    logic [DATA_W-1:0] r;
    r = v;
    r[idx] = val;
    return r;
  endfunction
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int BASE = RAM_BASE
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ptr0,
  input  logic [DW-1:0] ptr1,
  output logic [AW-1:0] eff_addr,
  output logic          redirected,
  output logic          null_hit,
  output logic          reserved_hit,
  output logic          reg_hit,
  output logic          ram_hit
);
  logic eff_is_port;

  always_comb begin
    redirected = 1'b1;
    if (addr == AW'(PORT0_A))      eff_addr = ptr0[AW-1:0];
    else if (addr == AW'(PORT1_A)) eff_addr = ptr1[AW-1:0];
    else begin
      eff_addr   = addr;
      redirected = 1'b0;
    end
  end

  assign eff_is_port  = (eff_addr == AW'(PORT0_A)) || (eff_addr == AW'(PORT1_A));
  assign null_hit     = eff_is_port;
  assign ram_hit      = (eff_addr >= AW'(BASE));
  assign reg_hit      = !ram_hit && is_reg_slot(int'(eff_addr));
  assign reserved_hit = !ram_hit && !reg_hit && !null_hit;
endmodule

// File: rtl/dmem_regfile.sv
module dmem_regfile
  import dmem_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int SLOTS = RAM_BASE,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ptr0,
  output logic [DW-1:0] ptr1
);
  logic [DW-1:0] slot [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (is_reg_slot(i)) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        slot[i] <= '0;
        else if (we && (idx == IW'(i)))    slot[i] <= wdata;
      end
    end else begin : g_hole
      assign slot[i] = '0;
    end
  end

  assign rdata = slot[idx];
  assign ptr0  = slot[PTR0_A];
  assign ptr1  = slot[PTR1_A];
endmodule

// File: rtl/dmem_gpram.sv
module dmem_gpram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/dmem_space.sv
module dmem_space
  import dmem_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int BASE = RAM_BASE,
  localparam int RAM_DEPTH = (1 << AW) - BASE,
  localparam int RAM_IW    = $clog2(RAM_DEPTH),
  localparam int REG_IW    = $clog2(BASE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          bit_en,
  input  logic [2:0]    bit_idx,
  input  logic          bit_set,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] eff_addr;
  logic          redirected, null_hit, reserved_hit, reg_hit, ram_hit;
  logic [DW-1:0] ptr0, ptr1, reg_rd, ram_rd, cur_byte, commit_data;
  logic          commit, reg_we, ram_we;
  logic [RAM_IW-1:0] ram_idx;
  logic [AW-1:0]     ram_off;

  dmem_decode #(.AW(AW), .DW(DW), .BASE(BASE)) u_decode (
    .addr(addr), .ptr0(ptr0), .ptr1(ptr1), .eff_addr(eff_addr),
    .redirected(redirected), .null_hit(null_hit), .reserved_hit(reserved_hit),
    .reg_hit(reg_hit), .ram_hit(ram_hit)
  );

  assign ram_off = eff_addr - AW'(BASE);
  assign ram_idx = ram_off[RAM_IW-1:0];

  dmem_regfile #(.DW(DW), .SLOTS(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(eff_addr[REG_IW-1:0]),
    .wdata(commit_data), .rdata(reg_rd), .ptr0(ptr0), .ptr1(ptr1)
  );

  dmem_gpram #(.DW(DW), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ram_idx),
    .wdata(commit_data), .rdata(ram_rd)
  );

  // target byte: zero for holes and null ports (R5, R6)
  always_comb begin
    if (ram_hit)      cur_byte = ram_rd;
    else if (reg_hit) cur_byte = reg_rd;
    else              cur_byte = '0;
  end

  // R9: byte write wins over bit operation
  assign commit_data = wr_en ? wdata : bit_apply(cur_byte, bit_idx, bit_set);
  assign commit      = (wr_en || bit_en) && (ram_hit || reg_hit);
  assign reg_we      = commit && reg_hit;
  assign ram_we      = commit && ram_hit;
  assign rdata       = cur_byte;
endmodule

// File: rtl/dmem_space_chk.sv
module dmem_space_chk #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          wr_en,
  input logic          bit_en,
  input logic [2:0]    bit_idx,
  input logic          bit_set,
  input logic [DW-1:0] rdata,
  input logic          null_hit,
  input logic          reserved_hit,
  input logic          ram_hit,
  input logic          reg_hit,
  input logic          redirected,
  input logic          commit
);
  // R6
  assert_hole_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_hit |-> rdata == '0);
  // R5
  assert_null_port_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    null_hit |-> (rdata == '0 && !commit));
  // R8: bit operations never land on holes or null targets
  assert_bitop_no_hole_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (reserved_hit || null_hit)) |-> !commit);
  // R3/R4: null targets only arise through redirection
  assert_null_only_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    null_hit |-> redirected);
  assert_one_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({null_hit, reserved_hit, ram_hit, reg_hit}));
  // R2: a byte write to direct RAM reads back next cycle at the same address
  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ram_hit && !redirected) |=>
      (addr != $past(addr) || rdata == $past(wdata)));
  // R7: the selected bit takes the requested value
  assert_bit_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !wr_en && ram_hit && !redirected) |=>
      (addr != $past(addr) || rdata[$past(bit_idx)] == $past(bit_set)));
endmodule

bind dmem_space dmem_space_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .bit_en(bit_en), .bit_idx(bit_idx), .bit_set(bit_set), .rdata(rdata),
  .null_hit(null_hit), .reserved_hit(reserved_hit), .ram_hit(ram_hit),
  .reg_hit(reg_hit), .redirected(redirected), .commit(commit)
);

// File: tb/dmem_space_bench.sv
`timescale 1ns/1ps
module dmem_space_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, bit_en = 1'b0, bit_set = 1'b0;
  logic [2:0] bit_idx = '0;
  logic [7:0] rdata;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [7:0] model [128];

  always #5 clk = ~clk;

  dmem_space u_dmem_space (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .bit_en(bit_en), .bit_idx(bit_idx), .bit_set(bit_set), .rdata(rdata)
  );

  // R10 slot list, written as ranges
  function automatic bit storage_at(int a);
    if (a >= 64) return 1;
    if (a == 1 || a == 3) return 1;
    if (a inside {[4:11]}) return 1;
    if (a == 18 || a == 20 || a == 30) return 1;
    if (a inside {[32:37]}) return 1;
    return 0;
  endfunction

  function automatic int target_of(int a);
    if (a == 0) return model[1] % 128;
    if (a == 2) return model[3] % 128;
    return a;
  endfunction

  function automatic logic [7:0] model_read(int a);
    int t;
    t = target_of(a);
    return storage_at(t) ? model[t] : 8'h00;
  endfunction

  function automatic string tag_of(int a, bit w, bit b);
    int t;
    t = target_of(a);
    if ((a == 0 || a == 2) && (t == 0 || t == 2)) return "R5";
    if (b && !w && (a == 0 || a == 2 || !storage_at(t))) return "R8";
    if (!storage_at(t)) return "R6";
    if (a == 0) return "R3";
    if (a == 2) return "R4";
    if (w && b) return "R9";
    if (b) return "R7";
    if (a < 64) return "R10";
    return "R2";
  endfunction

  task automatic apply(input int a, input logic [7:0] d, input bit w, input bit b,
                       input int bi, input bit bs, input string tag = "");
    logic [7:0] exp;
    int t;
    string tg;
    addr = 7'(a); wdata = d; wr_en = w; bit_en = b; bit_idx = 3'(bi); bit_set = bs;
    #2;
    exp = model_read(a);
    tg  = (tag != "") ? tag : tag_of(a, w, b);
    vectors++;
    if (rdata !== exp) begin
      misses++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", tg, a, rdata, exp);
    end
    @(posedge clk);
    t = target_of(a);
    if (storage_at(t)) begin
      if (w) model[t] = d;
      else if (b) model[t][bi] = bs;
    end
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    apply(a, d, 1, 0, 0, 0);
  endtask
  task automatic rd(input int a, input string tag = "");
    apply(a, 8'h00, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state everywhere
    for (int i = 0; i < 128; i++) rd(i, "R1");
    // R2, R10, R6: fill every address, then read back
    for (int i = 0; i < 128; i++) wr(i, 8'(i * 7 + 3));
    for (int i = 0; i < 128; i++) rd(i);
    // R3: port 0 through pointer at 01H
    wr(1, 8'h45); wr(0, 8'hA5); rd(8'h45, "R3"); rd(0, "R3");
    wr(1, 8'hC7); rd(0, "R3"); wr(0, 8'h3C); rd(8'h47, "R3");
    // R4: port 1 through pointer at 03H
    wr(3, 8'h21); wr(2, 8'h99); rd(8'h21, "R4"); rd(2, "R4");
    // R5: null pointers
    wr(1, 8'h02); rd(0, "R5"); wr(0, 8'hFF); apply(0, 0, 0, 1, 4, 1);
    wr(3, 8'h80); rd(2, "R5"); wr(2, 8'hEE);
    rd(1, "R5"); rd(3, "R5"); rd(0, "R5");
    // R6 via pointer to a hole, R8 bit ops through it
    wr(1, 8'h30); rd(0, "R6"); apply(0, 0, 0, 1, 0, 1); rd(8'h30, "R8");
    apply(8'h13, 0, 0, 1, 7, 1); rd(8'h13, "R8");
    // R7: bit ops on RAM and slots
    wr(8'h50, 8'h0F);
    for (int b = 0; b < 8; b++) apply(8'h50, 0, 0, 1, b, ~b[0]);
    rd(8'h50, "R7");
    // R8: bit op redirected through port 1
    wr(3, 8'h60); apply(2, 0, 0, 1, 6, 1); rd(8'h60, "R8");
    // R9: both strobes
    apply(8'h22, 8'h5A, 1, 1, 0, 1); rd(8'h22, "R9");
    // random traffic, biased toward the ports and pointers
    for (int n = 0; n < 6000; n++) begin
      int a;
      a = ($urandom % 4 == 0) ? int'($urandom % 4) : int'($urandom % 128);
      apply(a, 8'($urandom), ($urandom % 3 == 0), ($urandom % 4 == 0),
            int'($urandom % 8), 1'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule